// File: doc/BRIEF.md
# J1850 Link Controller Transmit Sequencer

This block holds the transmit-side control state of a byte-level J1850-style data link controller. A host writes one control register over a simple write strobe. The register holds:

- a fast receive-only speed select;
- a normalization-bit format select;
- an end-of-data request;
- three in-frame-response type bits.

The block tracks a transmit shift register and a one-byte shadow register behind it. It decides when the 8-bit CRC byte is placed into the shift register after the last data byte.

Symbol encoding, bit timing and arbitration are not part of this block. They are represented by strobes. `byte_done` marks the end of each byte shifted onto the bus. `crc_bit` marks the start of a CRC bit. `eod_seen` marks a valid end-of-data symbol received back. `bus_err` marks a detected error. The block reports the following:

- whether the shift register holds data or the CRC placeholder;
- the byte being sent;
- the data-register-empty flag;
- the priority-encoded response type;
- the normalization bit value to use.

Top module: `j1850_txctl`

## Requirements
- R1: After reset, `rd_data` is 0, `tx_busy` is 0, `tx_crc` is 0 and `tdre` is 1.
- R2: The control register bits are: [0] multi-byte response type 0, [1] multi-byte response type 1, [2] single-byte response, [3] end-of-data, [4] normalization format, [5] fast receive-only. While bit 5 is 1, `dat_wr` is ignored, a 1 written to bit 3 is ignored, and `tdre` is 0. In that state `tx_busy` stays 0.
- R3: Suppose end-of-data is set while the shadow register is empty and a CRC is used. The shift register then holds the CRC placeholder (`tx_crc`=1) from the cycle after the current byte's `byte_done`. It becomes empty after the next `byte_done`.
- R4: Suppose end-of-data is set while the shadow register is full. The first `byte_done` moves the shadow byte into the shift register with `tx_crc`=0. The CRC placeholder follows only after the second `byte_done`.
- R5: Writing 1 to bit 3 makes `tdre` 0 from the next cycle. `tdre` is 1 only when the shadow register is empty, end-of-data is clear and bit 5 is 0.
- R6: For a normal frame (bits [2:0] all 0), end-of-data clears on a `crc_bit` strobe while the CRC placeholder is in the shift register. Writing 0 to bit 3 does not clear it.
- R7: While any response type bit is set, end-of-data ignores `crc_bit`. It clears on `eod_seen`.
- R8: `bus_err` clears end-of-data, drops any pending CRC, and empties both the shift register and the shadow register.
- R9: `ifr_sel` is the priority-encoded response type, with at most one bit set. Bit 2 has the highest priority, then bit 1, then bit 0. For example, 011 gives 010 and 111 gives 100.
- R10: `rd_data` returns {2'b00, bit5, bit4, end-of-data, raw bits [2:0]}, so conflicting response bits read back exactly as written.
- R11: A CRC is used for normal frames and for type-1 multi-byte responses only. `nb_val` is 0 when a CRC is used and bit 4 is 1, and 1 when no CRC is used and bit 4 is 1. Both values are inverted when bit 4 is 0.
- R12: In a response that uses no CRC (single-byte or type-0), end-of-data never loads the CRC placeholder. The shift register becomes empty after the last `byte_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register read value |
| dat_wr | input | 1 | Transmit byte write strobe |
| dat_in | input | DW | Transmit byte |
| byte_done | input | 1 | End of the byte in the shift register |
| crc_bit | input | 1 | Start of a CRC bit on the bus |
| eod_seen | input | 1 | Valid end-of-data symbol received back |
| bus_err | input | 1 | Bus error detected |
| tx_busy | output | 1 | Shift register occupied |
| tx_crc | output | 1 | Shift register holds the CRC placeholder |
| tx_byte | output | DW | Byte in the shift register (0 while `tx_crc` is 1) |
| tdre | output | 1 | Transmit data register empty |
| ifr_sel | output | 3 | Encoded response type {single, multi1, multi0} |
| nb_val | output | 1 | Normalization bit value |
| rx_fast | output | 1 | Fast receive-only mode active |

## Verification
The embedded assertions check the following on every cycle:
- the one-hot encoding of the response type;
- the empty flag dropping after an end-of-data write;
- a full shadow register always being sent before the CRC;
- the shift register staying idle in fast receive mode;
- error recovery.

Only the bench scenarios can show the following:
- the exact byte order with the shadow register empty and with it full;
- the different self-clear events of normal frames and responses;
- the raw read-back against the encoded value;
- the normalization-bit table.

// File: rtl/j1850_txctl.sv
module j1850_txctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [7:0]    wr_data,
  output logic [7:0]    rd_data,
  input  logic          dat_wr,
  input  logic [DW-1:0] dat_in,
  input  logic          byte_done,
  input  logic          crc_bit,
  input  logic          eod_seen,
  input  logic          bus_err,
  output logic          tx_busy,
  output logic          tx_crc,
  output logic [DW-1:0] tx_byte,
  output logic          tdre,
  output logic [2:0]    ifr_sel,
  output logic          nb_val,
  output logic          rx_fast
);

  logic [2:0]    ifr_raw;
  logic          eod, nbfs, rx4x;
  logic [DW-1:0] sh_q, sd_q;
  logic          sh_full, sd_full, sh_crc, crc_pend;

  function automatic logic [2:0] prio(input logic [2:0] r);
    prio = r[2] ? 3'b100 : r[1] ? 3'b010 : r[0] ? 3'b001 : 3'b000;
  endfunction

  assign ifr_sel = prio(ifr_raw);
  wire in_ifr    = |ifr_raw;
  wire crc_use   = ~in_ifr | ifr_sel[1];
  wire [2:0] w_sel = prio(wr_data[2:0]);
  wire crc_use_w = ~(|wr_data[2:0]) | w_sel[1];
  wire eod_set   = wr_en & wr_data[3] & ~rx4x;
  wire take_in   = dat_wr & ~rx4x & ~sd_full;
  wire sh_free   = ~sh_full | byte_done;

  assign nb_val  = nbfs ? ~crc_use : crc_use;
  assign tdre    = ~sd_full & ~eod & ~rx4x;
  assign tx_busy = sh_full;
  assign tx_crc  = sh_crc;
  assign tx_byte = sh_crc ? '0 : sh_q;
  assign rx_fast = rx4x;
  assign rd_data = {2'b00, rx4x, nbfs, eod, ifr_raw};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ifr_raw <= '0;
      nbfs    <= 1'b0;
      rx4x    <= 1'b0;
    end else if (wr_en) begin
      ifr_raw <= wr_data[2:0];
      nbfs    <= wr_data[4];
      rx4x    <= wr_data[5];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                               eod <= 1'b0;
    else if (bus_err)                         eod <= 1'b0;
    else if (eod_set)                         eod <= 1'b1;
    else if (eod && !in_ifr && crc_bit && sh_crc) eod <= 1'b0;
    else if (eod && in_ifr && eod_seen)       eod <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || bus_err) begin
      sh_q     <= '0;
      sd_q     <= '0;
      sh_full  <= 1'b0;
      sd_full  <= 1'b0;
      sh_crc   <= 1'b0;
      crc_pend <= 1'b0;
    end else begin
      if (sh_free) begin
        if (sd_full) begin
          sh_q    <= sd_q;
          sh_full <= 1'b1;
          sh_crc  <= 1'b0;
          sd_full <= take_in;
          if (take_in) sd_q <= dat_in;
        end else if (crc_pend && !rx4x) begin
          sh_full  <= 1'b1;
          sh_crc   <= 1'b1;
          crc_pend <= 1'b0;
          sd_full  <= take_in;
          if (take_in) sd_q <= dat_in;
        end else if (take_in) begin
          sh_q    <= dat_in;
          sh_full <= 1'b1;
          sh_crc  <= 1'b0;
        end else begin
          sh_full <= 1'b0;
          sh_crc  <= 1'b0;
        end
      end else if (take_in) begin
        sd_q    <= dat_in;
        sd_full <= 1'b1;
      end
      if (eod_set && crc_use_w) crc_pend <= 1'b1;
    end
  end

  assert_sel_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ifr_sel));

  assert_eod_drops_tdre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[3] && !rx_fast && !bus_err) |=> !tdre);

  assert_shadow_before_crc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && tx_busy && sd_full && !bus_err) |=> (tx_busy && !tx_crc));

  assert_fast_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fast && !tx_busy) |=> !tx_busy);

  assert_err_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> (!tx_busy && !rd_data[3]));

endmodule

// File: tb/sim_j1850_txctl.sv
module sim_j1850_txctl;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, dat_wr = 0, byte_done = 0, crc_bit = 0, eod_seen = 0, bus_err = 0;
  logic [7:0] wr_data = 0, dat_in = 0, rd_data, tx_byte;
  logic tx_busy, tx_crc, tdre, nb_val, rx_fast;
  logic [2:0] ifr_sel;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  j1850_txctl #(.DW(8)) u0 (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .dat_wr, .dat_in,
    .byte_done, .crc_bit, .eod_seen, .bus_err, .tx_busy, .tx_crc, .tx_byte, .tdre,
    .ifr_sel, .nb_val, .rx_fast);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic dat(input logic [7:0] d);
    @(negedge clk); dat_wr = 1; dat_in = d;
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic done_p();
    @(negedge clk); byte_done = 1;
    @(negedge clk); byte_done = 0;
  endtask

  task automatic crc_p();
    @(negedge clk); crc_bit = 1;
    @(negedge clk); crc_bit = 0;
  endtask

  task automatic eodrx_p();
    @(negedge clk); eod_seen = 1;
    @(negedge clk); eod_seen = 0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 0);
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 tx_crc", tx_crc, 0);
    chk("R1 tdre", tdre, 1);
  endtask

  task automatic t_prio();
    wr(8'h03); chk("R9 011 sel", ifr_sel, 3'b010); chk("R10 011 raw", rd_data, 8'h03);
    wr(8'h07); chk("R9 111 sel", ifr_sel, 3'b100); chk("R10 111 raw", rd_data, 8'h07);
    wr(8'h01); chk("R9 001 sel", ifr_sel, 3'b001);
    wr(8'h00); chk("R9 000 sel", ifr_sel, 3'b000);
  endtask

  task automatic t_nb();
    wr(8'h12); chk("R11 fmt1 crc", nb_val, 0);
    wr(8'h14); chk("R11 fmt1 nocrc", nb_val, 1);
    wr(8'h02); chk("R11 fmt0 crc", nb_val, 1);
    wr(8'h04); chk("R11 fmt0 nocrc", nb_val, 0);
    wr(8'h00);
  endtask

  task automatic t_crc_empty();
    dat(8'hA5);
    chk("R3 busy", tx_busy, 1); chk("R3 byte", tx_byte, 8'hA5); chk("R5 tdre before", tdre, 1);
    wr(8'h08); chk("R5 tdre after eod", tdre, 0);
    wr(8'h00); chk("R6 write0 no clear", rd_data[3], 1);
    done_p(); chk("R3 crc loaded", tx_crc, 1); chk("R3 crc busy", tx_busy, 1);
    crc_p(); chk("R6 eod cleared", rd_data[3], 0);
    done_p(); chk("R3 idle", tx_busy, 0); chk("R5 tdre back", tdre, 1);
  endtask

  task automatic t_crc_full();
    dat(8'h11); dat(8'h22);
    chk("R5 shadow full tdre", tdre, 0);
    wr(8'h08);
    done_p(); chk("R4 shadow moved", tx_byte, 8'h22); chk("R4 no crc yet", tx_crc, 0);
    done_p(); chk("R4 crc after shadow", tx_crc, 1);
    crc_p(); chk("R6 eod cleared full", rd_data[3], 0);
    done_p(); chk("R4 idle", tx_busy, 0);
  endtask

  task automatic t_ifr_single();
    wr(8'h04); dat(8'h33); wr(8'h0C);
    done_p(); chk("R12 no crc", tx_crc, 0); chk("R12 idle", tx_busy, 0);
    crc_p(); chk("R7 crc_bit ignored", rd_data[3], 1);
    eodrx_p(); chk("R7 eod_seen clears", rd_data[3], 0);
    wr(8'h00);
  endtask

  task automatic t_ifr_multi1();
    wr(8'h02); dat(8'h44); wr(8'h0A);
    done_p(); chk("R11 m1 crc used", tx_crc, 1);
    crc_p(); chk("R7 m1 crc_bit ignored", rd_data[3], 1);
    done_p(); eodrx_p(); chk("R7 m1 cleared", rd_data[3], 0);
    wr(8'h00);
  endtask

  task automatic t_err();
    dat(8'h55); dat(8'h66); wr(8'h08);
    @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0;
    chk("R8 eod", rd_data[3], 0); chk("R8 busy", tx_busy, 0); chk("R8 tdre", tdre, 1);
    done_p(); chk("R8 no crc left", tx_busy, 0);
  endtask

  task automatic t_fast();
    wr(8'h20); chk("R2 rx_fast", rx_fast, 1); chk("R2 tdre", tdre, 0);
    dat(8'h77); chk("R2 data ignored", tx_busy, 0);
    wr(8'h28); chk("R2 eod ignored", rd_data[3], 0);
    wr(8'h00); chk("R2 still idle", tx_busy, 0); chk("R2 tdre back", tdre, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_prio();
    t_nb();
    t_crc_empty();
    t_crc_full();
    t_ifr_single();
    t_ifr_multi1();
    t_err();
    t_fast();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule